// File: doc/BRIEF.md
# Axis Limit and Reference Switch Stop Logic

This block sits beside the motion generator of one stepper axis and decides when a switch at either end of travel must halt the motor. It filters the left and right switch levels, qualifies them against the current driving direction and a velocity-nonzero flag, and issues a latched stop request together with the kind of stop to perform. The ramp generator reads the request and the mode; the block drives no motion itself.

Either switch can also act as the reference switch, which is used for homing. A select bit picks the side. The reference status and a one-cycle event on its rising edge are produced independently of the stop path. The same input can therefore end travel, mark the home position, or do both.

A four-bit configuration word is loaded when `cfgWrite` pulses. Rewriting it also releases a held stop, so software can back the axis out of a switch with new settings.

Top module: `axis_limit_stop`

## Requirements
- R1: The configuration register loads `cfgWord` on a cycle with `cfgWrite` high and holds otherwise. Bit 0 is the reference select, bit 1 disables the left stop, bit 2 disables the right stop and bit 3 selects a soft stop. After reset the register is zero.
- R2: Each switch input passes through a two-flop synchronizer. Its filtered level changes only after three consecutive synchronized samples agree. A pulse of two cycles or less has no effect on any output.
- R3: `refActive` equals the filtered right switch when bit 0 is 1, and the filtered left switch when bit 0 is 0.
- R4: A stop is set only by the switch on the driving side. `dirPos`=1 selects the right switch and `dirPos`=0 the left switch. The switch on the other side never sets a stop.
- R5: While `velNonZero` is 0, no new stop is set.
- R6: Bit 1 set prevents the left switch from setting a stop, and bit 2 set prevents the right switch from setting one.
- R7: Once set, `stopReq` stays high until either of two events. One is a cycle with `velNonZero` high and `dirPos` opposite to the side that caused the stop. The other is a `cfgWrite`, which clears it in the following cycle.
- R8: `stopSoft` is 1 while `stopReq` is high and bit 3 is set, meaning a ramped stop. It is 0 for an abrupt stop and whenever no stop is requested.
- R9: `refEvent` is high for exactly one cycle each time `refActive` rises, and is low otherwise.
- R10: While reset is asserted and directly after it, `stopReq`, `stopSoft`, `refActive` and `refEvent` are 0.
- R11: One switch may produce the reference status and a stop request at the same time. Neither path masks the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| swLeft | input | 1 | Left switch level, asynchronous, active high |
| swRight | input | 1 | Right switch level, asynchronous, active high |
| dirPos | input | 1 | Driving direction, 1 = positive (towards the right switch) |
| velNonZero | input | 1 | High while the commanded velocity is not zero |
| cfgWrite | input | 1 | Load strobe for the configuration word |
| cfgWord | input | 4 | Configuration: bit0 reference select, bit1 left stop disable, bit2 right stop disable, bit3 soft stop |
| stopReq | output | 1 | Latched stop request to the motion generator |
| stopSoft | output | 1 | Stop mode: 1 ramped, 0 abrupt |
| refActive | output | 1 | Filtered level of the selected reference switch |
| refEvent | output | 1 | One-cycle pulse on the rising edge of refActive |

## Verification
Short two-cycle switch pulses are tried against a three-cycle pulse, which separates the filter threshold from a plain synchronizer. Random steps combine switch levels with direction, velocity and configuration words. These steps tell a direction-qualified stop from one driven by either switch, show when the per-side disables apply, and show when the held stop is released by reverse motion as opposed to a configuration write. Steps where switches and direction change together exercise the window in which the stop logic still sees the old filtered levels. Configuration writes that move the reference selection onto an already active switch show that the event follows the selected status rather than the raw edge.

// File: rtl/axis_limit_pkg.sv
package axis_limit_pkg;
  localparam int CFG_W = 4;

  typedef struct packed {
    logic softStop;
    logic noStopRight;
    logic noStopLeft;
    logic refRight;
  } limCfg_t;

  typedef struct packed {
    logic setStop;
    logic clrStop;
    logic loadCfg;
  } ctrlStb_t;
endpackage

// File: rtl/limsw_filter.sv
module limsw_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_SAMPLES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level
);
  localparam int HIST_W = DEB_SAMPLES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [HIST_W-1:0]      hist;
  logic [DEB_SAMPLES-1:0] window;

  assign window = {hist, syncQ[SYNC_STAGES-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      hist  <= '0;
      level <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      hist  <= window[HIST_W-1:0];
      if (&window)       level <= 1'b1;
      else if (~|window) level <= 1'b0;
    end
  end

  // R2
  deb_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level != $past(level)) |-> ($past(window) == {DEB_SAMPLES{level}}));
endmodule

// File: rtl/limsw_datapath.sv
module limsw_datapath
  import axis_limit_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_SAMPLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swLeft,
  input  logic             swRight,
  input  logic             dirPos,
  input  logic [CFG_W-1:0] cfgWord,
  input  ctrlStb_t         stb,
  output logic             debLeft,
  output logic             debRight,
  output logic             cfgNoStopLeft,
  output logic             cfgNoStopRight,
  output logic             cfgSoft,
  output logic             stopLatch,
  output logic             stopSideRight,
  output logic             refActive,
  output logic             refEvent
);
  localparam int N_SIDES = 2;

  logic [N_SIDES-1:0] rawSw;
  logic [N_SIDES-1:0] deb;
  limCfg_t            cfgQ;
  logic               refPrev;

  assign rawSw = {swRight, swLeft};

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    limsw_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_SAMPLES(DEB_SAMPLES)) i_filter (
      .clk(clk), .rstN(rstN), .rawIn(rawSw[s]), .level(deb[s])
    );
  end

  assign debLeft        = deb[0];
  assign debRight       = deb[1];
  assign cfgNoStopLeft  = cfgQ.noStopLeft;
  assign cfgNoStopRight = cfgQ.noStopRight;
  assign cfgSoft        = cfgQ.softStop;
  assign refActive      = cfgQ.refRight ? deb[1] : deb[0];
  assign refEvent       = refActive & ~refPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ          <= '0;
      stopLatch     <= 1'b0;
      stopSideRight <= 1'b0;
      refPrev       <= 1'b0;
    end else begin
      refPrev <= refActive;
      if (stb.loadCfg) cfgQ <= limCfg_t'(cfgWord);
      if (stb.clrStop) begin
        stopLatch <= 1'b0;
      end else if (stb.setStop) begin
        stopLatch     <= 1'b1;
        stopSideRight <= dirPos;
      end
    end
  end

  // R9
  ref_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    refEvent |=> !refEvent);

  // R7
  cfg_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCfg |=> !stopLatch);
endmodule

// File: rtl/limsw_ctrl.sv
module limsw_ctrl
  import axis_limit_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     debLeft,
  input  logic     debRight,
  input  logic     cfgNoStopLeft,
  input  logic     cfgNoStopRight,
  input  logic     stopLatch,
  input  logic     stopSideRight,
  input  logic     dirPos,
  input  logic     velNonZero,
  input  logic     cfgWrite,
  output ctrlStb_t stb
);
  logic hitRight, hitLeft, hitAhead, reversing;

  assign hitRight  = debRight & ~cfgNoStopRight;
  assign hitLeft   = debLeft & ~cfgNoStopLeft;
  assign hitAhead  = velNonZero & (dirPos ? hitRight : hitLeft);
  assign reversing = stopLatch & velNonZero & (dirPos != stopSideRight);

  always_comb begin
    stb         = '0;
    stb.loadCfg = cfgWrite;
    stb.setStop = hitAhead & ~cfgWrite;
    stb.clrStop = cfgWrite | (reversing & ~hitAhead);
  end

  // R4 R6
  dir_side_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopLatch) |-> ($past(dirPos) ? ($past(debRight) && !$past(cfgNoStopRight))
                                        : ($past(debLeft) && !$past(cfgNoStopLeft))));

  // R5
  no_vel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopLatch) |-> $past(velNonZero));
endmodule

// File: rtl/axis_limit_stop.sv
module axis_limit_stop
  import axis_limit_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_SAMPLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swLeft,
  input  logic             swRight,
  input  logic             dirPos,
  input  logic             velNonZero,
  input  logic             cfgWrite,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             stopReq,
  output logic             stopSoft,
  output logic             refActive,
  output logic             refEvent
);
  ctrlStb_t stb;
  logic debLeft, debRight, noStopL, noStopR, cfgSoft, stopLatch, stopSideRight;

  limsw_datapath #(.SYNC_STAGES(SYNC_STAGES), .DEB_SAMPLES(DEB_SAMPLES)) i_dp (
    .clk(clk), .rstN(rstN), .swLeft(swLeft), .swRight(swRight), .dirPos(dirPos),
    .cfgWord(cfgWord), .stb(stb), .debLeft(debLeft), .debRight(debRight),
    .cfgNoStopLeft(noStopL), .cfgNoStopRight(noStopR), .cfgSoft(cfgSoft),
    .stopLatch(stopLatch), .stopSideRight(stopSideRight),
    .refActive(refActive), .refEvent(refEvent)
  );

  limsw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .debLeft(debLeft), .debRight(debRight),
    .cfgNoStopLeft(noStopL), .cfgNoStopRight(noStopR), .stopLatch(stopLatch),
    .stopSideRight(stopSideRight), .dirPos(dirPos), .velNonZero(velNonZero),
    .cfgWrite(cfgWrite), .stb(stb)
  );

  assign stopReq  = stopLatch;
  assign stopSoft = stopLatch & cfgSoft;

  // R8
  soft_needs_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSoft |-> stopReq);
endmodule

// File: tb/test_axis_limit_stop.sv
`timescale 1ns/1ps
module test_axis_limit_stop;
  logic clk = 1'b0, rstN = 1'b0;
  logic swLeft = 1'b0, swRight = 1'b0, dirPos = 1'b0, velNonZero = 1'b0, cfgWrite = 1'b0;
  logic [3:0] cfgWord = 4'd0;
  logic stopReq, stopSoft, refActive, refEvent;

  int checks = 0, errors = 0, evCount = 0;
  logic mDebL = 0, mDebR = 0, mLatch = 0, mSide = 0;
  logic [3:0] mCfg = 4'd0;

  axis_limit_stop i_axis_limit_stop (
    .clk(clk), .rstN(rstN), .swLeft(swLeft), .swRight(swRight), .dirPos(dirPos),
    .velNonZero(velNonZero), .cfgWrite(cfgWrite), .cfgWord(cfgWord),
    .stopReq(stopReq), .stopSoft(stopSoft), .refActive(refActive), .refEvent(refEvent)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic setCond(logic dl, logic dr, logic dir, logic vel, logic [3:0] c);
    return vel & (dir ? (dr & ~c[2]) : (dl & ~c[1]));
  endfunction

  function automatic logic refOf(logic dl, logic dr, logic [3:0] c);
    return c[0] ? dr : dl;
  endfunction

  task automatic modelIter(input logic dl, input logic dr);
    for (int k = 0; k < 2; k++) begin
      if (setCond(dl, dr, dirPos, velNonZero, mCfg)) begin
        mLatch = 1'b1; mSide = dirPos;
      end else if (mLatch && velNonZero && dirPos != mSide) mLatch = 1'b0;
    end
  endtask

  task automatic checkOutputs(input logic expRef, input int expEv);
    check("R4 R6 R7 R11 stopReq", stopReq, mLatch);
    check("R8 stopSoft", stopSoft, mLatch & mCfg[3]);
    check("R3 R11 refActive", refActive, expRef);
    check("R9 refEvent count", evCount, expEv);
  endtask

  task automatic applyStep(input logic l, input logic r, input logic d, input logic v);
    logic oldRef, newRef;
    @(negedge clk);
    swLeft = l; swRight = r; dirPos = d; velNonZero = v;
    evCount = 0;
    for (int k = 0; k < 12; k++) begin @(negedge clk); evCount += refEvent; end
    modelIter(mDebL, mDebR);
    oldRef = refOf(mDebL, mDebR, mCfg);
    mDebL = l; mDebR = r;
    modelIter(l, r);
    newRef = refOf(l, r, mCfg);
    checkOutputs(newRef, int'(newRef & ~oldRef));
  endtask

  task automatic writeCfg(input logic [3:0] c);
    logic oldRef, newRef;
    @(negedge clk);
    cfgWord = c; cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
    check("R7 cfgWrite releases stop", stopReq, 0);
    evCount = refEvent;
    for (int k = 0; k < 6; k++) begin @(negedge clk); evCount += refEvent; end
    oldRef = refOf(mDebL, mDebR, mCfg);
    mCfg = c; mLatch = 1'b0;
    modelIter(mDebL, mDebR);
    newRef = refOf(mDebL, mDebR, mCfg);
    checkOutputs(newRef, int'(newRef & ~oldRef));
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    // R10: reset state
    swRight = 1'b1; dirPos = 1'b1; velNonZero = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 stopReq in reset", stopReq, 0);
    check("R10 refActive in reset", refActive, 0);
    check("R10 refEvent in reset", refEvent, 0);
    swRight = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R10 stopSoft after reset", stopSoft, 0);
    check("R10 stopReq after reset", stopReq, 0);

    // R1: soft stop + right reference
    writeCfg(4'b1001);

    // R2: two-cycle glitch is ignored
    @(negedge clk);
    swRight = 1'b1;
    repeat (2) @(negedge clk);
    swRight = 1'b0;
    evCount = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); evCount += refEvent; end
    check("R2 glitch stopReq", stopReq, 0);
    check("R2 glitch refActive", refActive, 0);
    check("R2 glitch refEvent", evCount, 0);

    // R2: three-cycle pulse is accepted
    swRight = 1'b1;
    repeat (3) @(negedge clk);
    swRight = 1'b0;
    evCount = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); evCount += refEvent; end
    check("R2 R4 pulse latched stopReq", stopReq, 1);
    check("R8 soft mode", stopSoft, 1);
    check("R9 pulse refEvent", evCount, 1);
    mLatch = 1'b1; mSide = 1'b1;

    // R7: reverse motion releases
    applyStep(1'b0, 1'b0, 1'b0, 1'b1);
    // R5: no velocity, right switch active
    applyStep(1'b0, 1'b1, 1'b1, 1'b0);
    // R4: opposite switch does not stop
    applyStep(1'b0, 1'b1, 1'b0, 1'b1);
    // R11: same switch stops and is reference
    applyStep(1'b0, 1'b1, 1'b1, 1'b1);
    // R6: disable right, rewrite clears, no re-latch
    writeCfg(4'b0100);
    applyStep(1'b1, 1'b1, 1'b1, 1'b1);

    for (int n = 0; n < 160; n++) begin
      if (n % 9 == 4) writeCfg(4'($urandom_range(0, 15)));
      applyStep(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) != 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule